// File: doc/BRIEF.md
# Commit-Time Basic Block Validator

This block sits at the retire end of a processor pipeline and holds architectural commit at every basic-block boundary until the block has been vetted. Retiring instructions arrive one per cycle with a block-end flag, a control-flow kind and the next address that control actually took. When the last instruction of a block retires, the validator latches its target and kind and raises a commit stall. It then waits for two inputs, in either order and at any later cycle: the running content hash of the block from an upstream hash unit, and a reference signature entry from an upstream fetch unit.

Once both are in hand, the validator spends one judging cycle on two checks. The low 32 bits of the computed hash must equal those of the reference hash. A control transfer must land on one of the successor addresses listed in the entry. If both checks pass, the stall is released. If either fails, or the entry is marked as absent, a one-cycle violation with a cause code is raised before the stall is released. A flush input abandons a pending block silently, so that speculative rollback is possible.

The controller has four states. IDLE: accept a block end and go to WAIT. WAIT: capture the hash and the entry as each arrives, go to JUDGE when both are held, or go back to IDLE on flush. JUDGE: go to FAULT on a failed check, to IDLE on a pass, or to IDLE on flush. FAULT: raise the violation and return to IDLE.

Top module: `bbv_validator`

## Requirements
- R1: While reset (rst_n low) is applied and right after it, cmt_stall, viol_valid and viol_cause are all 0.
- R2: A retiring instruction with cmt_blk_end=1, taken while cmt_stall is 0 and flush is 0, makes cmt_stall 1 from the next cycle on. An instruction with cmt_blk_end=0 leaves cmt_stall at 0.
- R3: The hash (hash_valid) and the entry (sig_valid) may arrive in different cycles after the block end, in either order. Each is captured in the first cycle its valid is seen, and cmt_stall stays 1 until both have been captured.
- R4: If both are captured at clock edge k and both checks pass, cmt_stall is 1 in the cycle after edge k (the judging cycle) and 0 from edge k+1 on, with no violation.
- R5: Only hash bits [31:0] are compared. A difference confined to bits [63:32] does not cause a violation.
- R6: A difference in hash bits [31:0] gives a violation with viol_cause = 2'b01.
- R7: The control-flow kind is 2'b00 for a fall-through, 2'b01 for a conditional branch, 2'b10 for a call or jump, and 2'b11 for a return. For any kind other than 2'b00, the block target must equal one of the successor entries, entry i being sig_succ[i*32 +: 32]. Otherwise the violation has viol_cause = 2'b10. A fall-through skips the target check.
- R8: Only entries with index below sig_cnt take part. A target that equals an entry at index sig_cnt or above is a violation, and a count of 0 with any control transfer is a violation.
- R9: An entry with sig_hit=0 gives viol_cause = 2'b11 whatever the hash and target. A hash mismatch takes precedence over a bad target.
- R10: A violation is a single-cycle pulse on viol_valid, in the cycle after the judging cycle, with cmt_stall still 1. cmt_stall is 0 in the following cycle. viol_cause is 0 whenever viol_valid is 0.
- R11: A flush while a block is pending (WAIT or JUDGE) makes cmt_stall 0 in the next cycle, with no violation. Nothing captured for the dropped block carries over to the next block. A flush in the same cycle as a block end cancels that block end.
- R12: Retiring instructions offered while cmt_stall is 1 are ignored. The pending block keeps its latched target and kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_valid | input | 1 | A retiring instruction is presented |
| cmt_blk_end | input | 1 | The instruction closes a basic block |
| cmt_cf_kind | input | 2 | Control-flow kind of the closing instruction |
| cmt_target | input | AW | Address that control actually moved to |
| hash_valid | input | 1 | Computed block hash is ready |
| hash_value | input | HW | Computed block hash |
| sig_valid | input | 1 | Reference entry is ready |
| sig_hit | input | 1 | Reference entry exists for this block |
| sig_hash | input | HW | Reference hash |
| sig_succ | input | NSUCC*AW | Allowed successor addresses, entry i at [i*AW +: AW] |
| sig_cnt | input | $clog2(NSUCC+1) | Number of valid successor entries |
| flush | input | 1 | Drop any pending block without an exception |
| cmt_stall | output | 1 | Commit must hold |
| viol_valid | output | 1 | Violation exception pulse |
| viol_cause | output | 2 | Violation cause: 01 hash, 10 target, 11 missing entry |

## Verification
The bench goes after late and out-of-order arrival of the hash and the entry. A design that judged as soon as one of them arrived would release the stall early or judge on stale data. It also covers hash words that differ only above bit 31, which a design comparing the full word would wrongly trap, and a target that matches only an entry past the valid count, which a design ignoring the count would wrongly accept. Flushes are placed after a partial capture, where leftover capture state would let a stale hash decide the next block. Stray block ends arrive during a stall, where overwriting the latched target would change the verdict.

// File: rtl/bbv_pkg.sv
package bbv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_JUDGE = 2'd2,
        ST_FAULT = 2'd3
    } bbv_state_e;

    typedef enum logic [1:0] {
        CF_NONE   = 2'b00,
        CF_BRANCH = 2'b01,
        CF_JUMP   = 2'b10,
        CF_RETURN = 2'b11
    } cf_kind_e;

    localparam logic [1:0] CAUSE_NONE   = 2'b00;
    localparam logic [1:0] CAUSE_HASH   = 2'b01;
    localparam logic [1:0] CAUSE_TARGET = 2'b10;
    localparam logic [1:0] CAUSE_NOSIG  = 2'b11;

endpackage

// File: rtl/bbv_capture.sv
// Holds the hash and the reference entry for the pending block; each is
// taken on the first cycle its valid is seen while armed.
module bbv_capture #(
    parameter int AW    = 32,
    parameter int HW    = 64,
    parameter int CW    = 32,
    parameter int NSUCC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        arm,
    input  logic                        hash_valid,
    input  logic [HW-1:0]               hash_value,
    input  logic                        sig_valid,
    input  logic                        sig_hit,
    input  logic [HW-1:0]               sig_hash,
    input  logic [NSUCC*AW-1:0]         sig_succ,
    input  logic [$clog2(NSUCC+1)-1:0]  sig_cnt,
    output logic                        both_ready,
    output logic [CW-1:0]               calc_q,
    output logic [CW-1:0]               ref_q,
    output logic                        hit_q,
    output logic [NSUCC*AW-1:0]         succ_q,
    output logic [$clog2(NSUCC+1)-1:0]  cnt_q
);
    logic have_hash_q;
    logic have_sig_q;
    logic take_hash;
    logic take_sig;

    generate
        if (CW < HW) begin : g_hi
            logic unused_hash_hi;
            assign unused_hash_hi = ^{hash_value[HW-1:CW], sig_hash[HW-1:CW]};
        end
    endgenerate

    assign take_hash  = arm && hash_valid && !have_hash_q;
    assign take_sig   = arm && sig_valid && !have_sig_q;
    assign both_ready = arm && (have_hash_q || hash_valid) && (have_sig_q || sig_valid);

    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            have_hash_q <= 1'b0;
            have_sig_q  <= 1'b0;
        end else begin
            if (take_hash) have_hash_q <= 1'b1;
            if (take_sig)  have_sig_q  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            calc_q <= '0;
            ref_q  <= '0;
            hit_q  <= 1'b0;
            succ_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (take_hash) calc_q <= hash_value[CW-1:0];
            if (take_sig) begin
                ref_q  <= sig_hash[CW-1:0];
                hit_q  <= sig_hit;
                succ_q <= sig_succ;
                cnt_q  <= sig_cnt;
            end
        end
    end
endmodule

// File: rtl/bbv_succ_match.sv
// Compares a target against the first cnt successor entries.
module bbv_succ_match #(
    parameter int AW    = 32,
    parameter int NSUCC = 4
) (
    input  logic [AW-1:0]               target,
    input  logic [NSUCC*AW-1:0]         succ,
    input  logic [$clog2(NSUCC+1)-1:0]  cnt,
    output logic                        hit
);
    localparam int CNTW = $clog2(NSUCC + 1);

    logic [NSUCC-1:0] lane_hit;

    generate
        for (genvar i = 0; i < NSUCC; i++) begin : g_lane
            assign lane_hit[i] = (cnt > CNTW'(i)) && (succ[i*AW +: AW] == target);
        end
    endgenerate

    assign hit = |lane_hit;
endmodule

// File: rtl/bbv_validator.sv
module bbv_validator #(
    parameter int AW    = 32,
    parameter int HW    = 64,
    parameter int CW    = 32,
    parameter int NSUCC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmt_valid,
    input  logic                        cmt_blk_end,
    input  logic [1:0]                  cmt_cf_kind,
    input  logic [AW-1:0]               cmt_target,
    input  logic                        hash_valid,
    input  logic [HW-1:0]               hash_value,
    input  logic                        sig_valid,
    input  logic                        sig_hit,
    input  logic [HW-1:0]               sig_hash,
    input  logic [NSUCC*AW-1:0]         sig_succ,
    input  logic [$clog2(NSUCC+1)-1:0]  sig_cnt,
    input  logic                        flush,
    output logic                        cmt_stall,
    output logic                        viol_valid,
    output logic [1:0]                  viol_cause
);
    import bbv_pkg::*;

    localparam int CNTW = $clog2(NSUCC + 1);

    bbv_state_e            state_q, state_d;
    logic [AW-1:0]         tgt_q;
    cf_kind_e              kind_q;
    logic [1:0]            cause_q;
    logic [1:0]            verdict;
    logic                  accept;
    logic                  both_ready;
    logic [CW-1:0]         calc_q;
    logic [CW-1:0]         ref_q;
    logic                  hit_q;
    logic [NSUCC*AW-1:0]   succ_q;
    logic [CNTW-1:0]       cnt_q;
    logic                  succ_hit;

    assign accept = (state_q == ST_IDLE) && cmt_valid && cmt_blk_end && !flush;

    bbv_capture #(.AW(AW), .HW(HW), .CW(CW), .NSUCC(NSUCC)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (state_q == ST_WAIT),
        .hash_valid (hash_valid),
        .hash_value (hash_value),
        .sig_valid  (sig_valid),
        .sig_hit    (sig_hit),
        .sig_hash   (sig_hash),
        .sig_succ   (sig_succ),
        .sig_cnt    (sig_cnt),
        .both_ready (both_ready),
        .calc_q     (calc_q),
        .ref_q      (ref_q),
        .hit_q      (hit_q),
        .succ_q     (succ_q),
        .cnt_q      (cnt_q)
    );

    bbv_succ_match #(.AW(AW), .NSUCC(NSUCC)) u_match (
        .target (tgt_q),
        .succ   (succ_q),
        .cnt    (cnt_q),
        .hit    (succ_hit)
    );

    // Verdict priority: missing entry, then hash, then target.
    always_comb begin
        if (!hit_q)
            verdict = CAUSE_NOSIG;
        else if (calc_q != ref_q)
            verdict = CAUSE_HASH;
        else if (kind_q != CF_NONE && !succ_hit)
            verdict = CAUSE_TARGET;
        else
            verdict = CAUSE_NONE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Block latch and verdict register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q   <= '0;
            kind_q  <= CF_NONE;
            cause_q <= CAUSE_NONE;
        end else begin
            if (accept) begin
                tgt_q  <= cmt_target;
                kind_q <= cf_kind_e'(cmt_cf_kind);
            end
            if (state_q == ST_JUDGE) cause_q <= verdict;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_WAIT;
            ST_WAIT: begin
                if (flush)           state_d = ST_IDLE;
                else if (both_ready) state_d = ST_JUDGE;
            end
            ST_JUDGE: begin
                if (flush)                      state_d = ST_IDLE;
                else if (verdict != CAUSE_NONE) state_d = ST_FAULT;
                else                            state_d = ST_IDLE;
            end
            ST_FAULT: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmt_stall  = 1'b1;
        viol_valid = 1'b0;
        viol_cause = CAUSE_NONE;
        unique case (state_q)
            ST_IDLE:  cmt_stall = 1'b0;
            ST_WAIT:  cmt_stall = 1'b1;
            ST_JUDGE: cmt_stall = 1'b1;
            ST_FAULT: begin
                viol_valid = 1'b1;
                viol_cause = cause_q;
            end
        endcase
    end
endmodule

// File: rtl/bbv_validator_chk.sv
module bbv_validator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmt_valid,
    input logic       cmt_blk_end,
    input logic       flush,
    input logic       cmt_stall,
    input logic       viol_valid,
    input logic [1:0] viol_cause
);
    a_r2_stall_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_blk_end && !cmt_stall && !flush) |=> cmt_stall);

    a_r2_stall_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmt_stall) |-> $past(cmt_valid && cmt_blk_end && !flush));

    a_r10_viol_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> cmt_stall);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |=> (!viol_valid && !cmt_stall));

    a_r10_cause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_valid |-> (viol_cause == 2'b00));

    a_r9_cause_coded: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_cause != 2'b00));

    a_r11_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!cmt_stall && !viol_valid));
endmodule

bind bbv_validator bbv_validator_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmt_valid   (cmt_valid),
    .cmt_blk_end (cmt_blk_end),
    .flush       (flush),
    .cmt_stall   (cmt_stall),
    .viol_valid  (viol_valid),
    .viol_cause  (viol_cause)
);

// File: tb/tb_bbv_validator.sv
module tb_bbv_validator;
    localparam int AW = 32;
    localparam int HW = 64;
    localparam int NS = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cmt_valid;
    logic            cmt_blk_end;
    logic [1:0]      cmt_cf_kind;
    logic [AW-1:0]   cmt_target;
    logic            hash_valid;
    logic [HW-1:0]   hash_value;
    logic            sig_valid;
    logic            sig_hit;
    logic [HW-1:0]   sig_hash;
    logic [NS*AW-1:0] sig_succ;
    logic [2:0]      sig_cnt;
    logic            flush;
    logic            cmt_stall;
    logic            viol_valid;
    logic [1:0]      viol_cause;

    logic [AW-1:0]   ref_succ [NS];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) sig_succ[i*AW +: AW] = ref_succ[i];
    end

    bbv_validator #(.AW(AW), .HW(HW), .CW(32), .NSUCC(NS)) dut (
        .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_blk_end(cmt_blk_end),
        .cmt_cf_kind(cmt_cf_kind), .cmt_target(cmt_target), .hash_valid(hash_valid),
        .hash_value(hash_value), .sig_valid(sig_valid), .sig_hit(sig_hit),
        .sig_hash(sig_hash), .sig_succ(sig_succ), .sig_cnt(sig_cnt), .flush(flush),
        .cmt_stall(cmt_stall), .viol_valid(viol_valid), .viol_cause(viol_cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] model(input logic hit, input logic [63:0] h,
                                         input logic [63:0] rh, input logic [1:0] kind,
                                         input logic [31:0] tgt, input logic [2:0] cnt);
        logic m = 1'b0;
        if (!hit) return 2'b11;
        if (h[31:0] != rh[31:0]) return 2'b01;
        for (int i = 0; i < NS; i++)
            if (i < int'(cnt) && ref_succ[i] == tgt) m = 1'b1;
        if (kind != 2'b00 && !m) return 2'b10;
        return 2'b00;
    endfunction

    function automatic string tag_of(input logic [1:0] c);
        case (c)
            2'b00:   return "R4";
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R9";
        endcase
    endfunction

    // Caller is at a negedge with the block idle.
    task automatic run_block(input logic hit, input logic [63:0] h, input logic [63:0] rh,
                             input logic [1:0] kind, input logic [31:0] tgt,
                             input logic [2:0] cnt, input int dh, input int ds,
                             input int flush_at, input bit stray, input string req);
        logic [1:0] ec = model(hit, h, rh, kind, tgt, cnt);
        int m = (dh > ds) ? dh : ds;
        bit fail = (ec != 2'b00);
        int last = (flush_at >= 0) ? flush_at + 1 : (fail ? m + 3 : m + 2);
        hash_value  = h;  sig_hash = rh;  sig_hit = hit;  sig_cnt = cnt;
        cmt_valid   = 1'b1; cmt_blk_end = 1'b1; cmt_cf_kind = kind; cmt_target = tgt;
        @(negedge clk);
        for (int c = 0; c <= last; c++) begin
            logic es = (c < last) ? 1'b1 : 1'b0;
            logic ev = (flush_at < 0 && fail && c == m + 2) ? 1'b1 : 1'b0;
            chk({req, " stall"}, {31'd0, cmt_stall}, {31'd0, es});
            chk({req, " viol"}, {29'd0, viol_valid, viol_cause}, {29'd0, ev, ev ? ec : 2'b00});
            if (c == last) break;
            hash_valid  = (c >= dh);
            sig_valid   = (c >= ds);
            flush       = (c == flush_at);
            cmt_valid   = stray && (c == 0);   // R12: offered during stall
            cmt_target  = ~tgt;
            cmt_cf_kind = 2'b10;
            @(negedge clk);
        end
        hash_valid = 1'b0; sig_valid = 1'b0; flush = 1'b0; cmt_valid = 1'b0;
        cmt_blk_end = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cmt_valid = 0; cmt_blk_end = 0; cmt_cf_kind = 0; cmt_target = 0;
        hash_valid = 0; hash_value = 0; sig_valid = 0; sig_hit = 0; sig_hash = 0;
        sig_cnt = 0; flush = 0;
        ref_succ[0] = 32'h1000; ref_succ[1] = 32'h2000;
        ref_succ[2] = 32'h3000; ref_succ[3] = 32'h4000;
        repeat (3) @(negedge clk);
        chk("R1 reset", {29'd0, cmt_stall, viol_valid, viol_cause}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {29'd0, cmt_stall, viol_valid, viol_cause}, 32'd0);

        // R2: non-final instruction does not stall
        cmt_valid = 1; cmt_blk_end = 0;
        @(negedge clk);
        chk("R2 no end", {31'd0, cmt_stall}, 32'd0);
        cmt_valid = 0;

        run_block(1, 64'hAA, 64'hAA, 2'b01, 32'h3000, 3'd3, 0, 0, -1, 0, "R4 pass");
        run_block(1, 64'hBB, 64'hBB, 2'b11, 32'h2000, 3'd4, 3, 1, -1, 0, "R3 late hash");
        run_block(1, 64'hCC, 64'hCC, 2'b10, 32'h1000, 3'd1, 0, 2, -1, 0, "R3 late sig");
        run_block(1, 64'h1_0000_00DD, 64'h2_0000_00DD, 2'b01, 32'h1000, 3'd2, 0, 0, -1, 0, "R5 high bits");
        run_block(1, 64'h00DE, 64'h00DD, 2'b01, 32'h1000, 3'd2, 1, 0, -1, 0, "R6 low bit");
        run_block(1, 64'h11, 64'h11, 2'b10, 32'h5000, 3'd4, 0, 0, -1, 0, "R7 bad target");
        run_block(1, 64'h12, 64'h12, 2'b00, 32'h5000, 3'd4, 0, 0, -1, 0, "R7 fallthrough");
        run_block(1, 64'h13, 64'h13, 2'b01, 32'h4000, 3'd3, 0, 0, -1, 0, "R8 past count");
        run_block(1, 64'h14, 64'h14, 2'b11, 32'h1000, 3'd0, 0, 1, -1, 0, "R8 zero count");
        run_block(0, 64'h15, 64'h99, 2'b01, 32'h5000, 3'd4, 0, 0, -1, 0, "R9 no entry");
        run_block(1, 64'h16, 64'h17, 2'b01, 32'h5000, 3'd4, 0, 0, -1, 0, "R9 hash first");
        run_block(1, 64'h18, 64'h19, 2'b10, 32'h1000, 3'd1, 0, 2, -1, 0, "R10 pulse");

        // R11: flush after a bad hash was captured; next block must not see it
        run_block(1, 64'hBAD, 64'h20, 2'b01, 32'h1000, 3'd1, 0, 3, 1, 0, "R11 flush");
        run_block(1, 64'h20, 64'h20, 2'b01, 32'h1000, 3'd1, 2, 0, -1, 0, "R11 no carry");
        run_block(1, 64'h21, 64'h21, 2'b01, 32'h1000, 3'd1, 0, 0, 1, 0, "R11 flush judge");
        cmt_valid = 1; cmt_blk_end = 1; flush = 1;
        @(negedge clk);
        chk("R11 flush cancels end", {31'd0, cmt_stall}, 32'd0);
        cmt_valid = 0; cmt_blk_end = 0; flush = 0;

        // R12: stray block end during stall must not replace the target
        run_block(1, 64'h22, 64'h22, 2'b01, 32'h2000, 3'd2, 1, 1, -1, 1, "R12 stray");

        for (int it = 0; it < 300; it++) begin
            logic hit = ($urandom % 8) != 0;
            logic [63:0] rh = {$urandom, $urandom};
            logic [63:0] h = rh;
            logic [2:0] cnt = 3'($urandom % 5);
            logic [1:0] kind = 2'($urandom);
            logic [31:0] tgt;
            int dh = $urandom % 4;
            int ds = $urandom % 4;
            int mm = (dh > ds) ? dh : ds;
            int fa = (($urandom % 8) == 0) ? int'($urandom % (mm + 2)) : -1;
            case ($urandom % 4)
                0: h[5] = ~h[5];
                1: h[40] = ~h[40];
                default: ;
            endcase
            for (int i = 0; i < NS; i++) ref_succ[i] = $urandom & 32'hFFFF_FFFC;
            tgt = (($urandom % 3) != 0) ? ref_succ[$urandom % NS] : $urandom;
            run_block(hit, h, rh, kind, tgt, cnt, dh, ds, fa, ($urandom % 4) == 0,
                      (fa >= 0) ? "R11 rand" : tag_of(model(hit, h, rh, kind, tgt, cnt)));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule